// File: doc/BRIEF.md
# Shared Word Memory with Indivisible Read-Modify-Write

This block puts one single-port word memory behind several requesters. Each requester issues one of four operations: a plain read, a plain write, an exchange (swap), or a compare-and-exchange. Every operation returns the value the word held before the operation. A round-robin arbiter picks one requester at a time.

An exchange or compare-and-exchange reads the word and then writes it in the next cycle. The memory stays owned by that requester for both cycles, so no other requester's access can fall between the read and the write. This makes the block suitable for lock words. A requester takes a lock by exchanging in 1, and owns it only if 0 comes back. It releases the lock with a plain write of 0.

Plain reads and writes are each indivisible on their own. A separate read followed by a separate write is not, because another requester may be granted in between.

Top module: `atomic_mem_arbiter`

## Requirements
- R1: After a synchronous active-low reset, every memory word reads as zero, no response is pending, and a port's `req_ready` is low unless that port's `req_valid` is high.
- R2: A plain read (op code 2'b00) returns the addressed word on `rsp_data` with `rsp_ok` low, and leaves memory unchanged.
- R3: A plain write (op code 2'b01) stores `req_wdata` at the address and returns the word's previous value.
- R4: A swap (op code 2'b10) stores `req_wdata` and returns the previous value as one indivisible operation.
- R5: A compare-and-swap (op code 2'b11) whose `req_cmp` equals the current word stores `req_wdata`, returns the old value, and raises `rsp_ok` with the response.
- R6: A compare-and-swap whose `req_cmp` differs from the current word leaves memory unchanged, returns the old value, and keeps `rsp_ok` low.
- R7: Once a request is accepted at a clock edge, `rsp_valid` pulses for one cycle, 2 edges later for a plain operation and 3 edges later for a swap or compare-and-swap. No request is accepted before the edge that raises that pulse, and acceptances are therefore at least 2 edges apart after a plain operation and 3 edges apart after an atomic one.
- R8: When several ports request together, the grant is round-robin. The port granted last has the lowest priority. After reset, port 0 has the highest priority.
- R9: When every port swaps 1 into the same zero lock word at once, exactly one port receives 0. After that port writes 0 back, the next swap of 1 receives 0.
- R10: A port whose request is not accepted keeps `req_valid` and its fields stable. It is served later with the memory contents at its own grant time, and `req_ready` is only ever high for a port whose `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NPORTS | Request pending, one bit per port |
| req_ready | output | NPORTS | Request accepted at this edge, at most one bit set |
| req_op | input | 2*NPORTS | Op code per port: 00 read, 01 write, 10 swap, 11 compare-and-swap |
| req_addr | input | AW*NPORTS | Word address per port |
| req_wdata | input | DW*NPORTS | Data to store per port |
| req_cmp | input | DW*NPORTS | Expected value for compare-and-swap per port |
| rsp_valid | output | NPORTS | One-cycle response pulse per port |
| rsp_data | output | DW*NPORTS | Previous word value, valid with rsp_valid |
| rsp_ok | output | NPORTS | Compare-and-swap performed its write, valid with rsp_valid |

## Verification
The hardest situation to reach is contention: several ports waiting with their requests held while an atomic sequence owns the memory, since only then can an interleaving between read and write appear. The stimulus releases all ports on the same clock edge, once with swaps on separate words to measure grant order and acceptance spacing, and once with every port racing for the same lock word. A long random run of single-port operations is then checked against a bench model of the memory.

// File: rtl/amx_pkg.sv
// Package: shared operation codes and sequencer states for the atomic memory arbiter.
// Assumes: op code values are part of the port contract and must not be renumbered.
package amx_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SWAP  = 2'b10,
        OP_CAS   = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_EXEC = 2'b01,
        ST_WB   = 2'b10
    } st_e;
endpackage

// File: rtl/amx_word_mem.sv
// Module: single-port word memory with asynchronous read and synchronous write.
// Assumes: one access per cycle; all words cleared by synchronous active-low reset.
module amx_word_mem #(
    parameter int AW = 4,
    parameter int DW = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] words [DEPTH];

    // Purpose: clear on reset, otherwise store on write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

    // Purpose: present the addressed word in the same cycle.
    assign rdata = words[addr];
endmodule

// File: rtl/amx_rr_arbiter.sv
// Module: round-robin arbiter; the last granted port has lowest priority next time.
// Assumes: grant is meaningful only when en is high; after reset port 0 ranks first.
module amx_rr_arbiter #(
    parameter int N = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [N-1:0]  valid,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] last_q;
    logic          found;
    int            cand;

    // Purpose: scan ports starting just after the last winner, pick the first valid one.
    always_comb begin
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        cand    = 0;
        for (int k = 1; k <= N; k++) begin
            cand = (int'(last_q) + k) % N;
            if (!found && valid[cand]) begin
                found         = 1'b1;
                gnt[cand]     = en;
                gnt_idx       = IW'(cand);
            end
        end
    end

    // Purpose: remember the winner of every granted decision.
    always_ff @(posedge clk) begin
        if (!rst_n)               last_q <= IW'(N - 1);
        else if (en && |valid)    last_q <= gnt_idx;
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R8
    AST_GNT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~valid) == '0); // R10
    AST_LAST_LOSES_TIE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $countones(valid) > 1) |-> !gnt[last_q]); // R8
endmodule

// File: rtl/amx_seq.sv
// Module: operation sequencer; latches one granted request and runs it on the memory.
// Plain ops take one execute cycle; swap and compare-and-swap add a write-back cycle
// during which nothing new is accepted, so the pair is indivisible.
// Assumes: take is high only while idle is high (grant is gated by idle).
module amx_seq #(
    parameter int N  = 3,
    parameter int AW = 4,
    parameter int DW = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [IW-1:0]   take_idx,
    input  logic [2*N-1:0]  req_op,
    input  logic [AW*N-1:0] req_addr,
    input  logic [DW*N-1:0] req_wdata,
    input  logic [DW*N-1:0] req_cmp,
    input  logic [DW-1:0]   mem_rdata,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            idle,
    output logic [N-1:0]    rsp_valid,
    output logic [DW-1:0]   rsp_data,
    output logic [N-1:0]    rsp_ok
);
    import amx_pkg::*;

    st_e           state_q;
    op_e           op_q;
    logic [IW-1:0] port_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] cmp_q;
    logic [DW-1:0] old_q;
    logic          is_atomic;
    logic          cas_hit;

    assign is_atomic = (op_q == OP_SWAP) || (op_q == OP_CAS);
    assign cas_hit   = (op_q == OP_CAS) && (old_q == cmp_q);
    assign idle      = (state_q == ST_IDLE);
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

    // Purpose: write in execute for plain writes, in write-back for swap or matching compare.
    always_comb begin
        mem_we = 1'b0;
        if (state_q == ST_EXEC && op_q == OP_WRITE)            mem_we = 1'b1;
        else if (state_q == ST_WB && (op_q == OP_SWAP || cas_hit)) mem_we = 1'b1;
    end

    // Purpose: state progression and capture of the granted request's fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_READ;
            port_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            cmp_q   <= '0;
            old_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (take) begin
                    op_q    <= op_e'(req_op[int'(take_idx)*2 +: 2]);
                    port_q  <= take_idx;
                    addr_q  <= req_addr[int'(take_idx)*AW +: AW];
                    wdata_q <= req_wdata[int'(take_idx)*DW +: DW];
                    cmp_q   <= req_cmp[int'(take_idx)*DW +: DW];
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    old_q   <= mem_rdata;
                    state_q <= is_atomic ? ST_WB : ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: one-cycle response pulse to the owning port with the previous word value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= '0;
            rsp_ok    <= '0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= '0;
            rsp_ok    <= '0;
            if (state_q == ST_EXEC && !is_atomic) begin
                rsp_valid[port_q] <= 1'b1;
                rsp_data          <= mem_rdata;
            end else if (state_q == ST_WB) begin
                rsp_valid[port_q] <= 1'b1;
                rsp_ok[port_q]    <= cas_hit;
                rsp_data          <= old_q;
            end
        end
    end

    AST_ATOMIC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && is_atomic) |=> (state_q == ST_WB && !idle)); // R7
    AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid)); // R7
    AST_OK_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ok & ~rsp_valid) == '0); // R5
    AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !take); // R7
endmodule

// File: rtl/atomic_mem_arbiter.sv
// Module: top of the shared word memory with indivisible swap and compare-and-swap.
// Assumes: requesters hold req_valid and fields stable until req_ready is seen high.
module atomic_mem_arbiter #(
    parameter int NPORTS = 3,
    parameter int AW     = 4,
    parameter int DW     = 32,
    localparam int IW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORTS-1:0]    req_valid,
    output logic [NPORTS-1:0]    req_ready,
    input  logic [2*NPORTS-1:0]  req_op,
    input  logic [AW*NPORTS-1:0] req_addr,
    input  logic [DW*NPORTS-1:0] req_wdata,
    input  logic [DW*NPORTS-1:0] req_cmp,
    output logic [NPORTS-1:0]    rsp_valid,
    output logic [DW*NPORTS-1:0] rsp_data,
    output logic [NPORTS-1:0]    rsp_ok
);
    logic          idle;
    logic [IW-1:0] gnt_idx;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] rsp_word;

    amx_rr_arbiter #(.N(NPORTS)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (idle),
        .valid   (req_valid),
        .gnt     (req_ready),
        .gnt_idx (gnt_idx)
    );

    amx_seq #(.N(NPORTS), .AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (|req_ready),
        .take_idx  (gnt_idx),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_cmp   (req_cmp),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .idle      (idle),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_word),
        .rsp_ok    (rsp_ok)
    );

    amx_word_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    // Purpose: the single response word is fanned out to every port's data lane.
    for (genvar p = 0; p < NPORTS; p++) begin : g_rsp
        assign rsp_data[p*DW +: DW] = rsp_word;
    end
endmodule

// File: tb/atomic_mem_arbiter_test.sv
`timescale 1ns/1ps
module atomic_mem_arbiter_test;
    localparam int N  = 3;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]    req_valid, req_ready, rsp_valid, rsp_ok;
    logic [2*N-1:0]  req_op;
    logic [AW*N-1:0] req_addr;
    logic [DW*N-1:0] req_wdata, req_cmp, rsp_data;

    logic          v_a [N];
    logic [1:0]    op_a [N];
    logic [AW-1:0] ad_a [N];
    logic [DW-1:0] wd_a [N];
    logic [DW-1:0] cm_a [N];

    always_comb begin
        for (int p = 0; p < N; p++) begin
            req_valid[p]            = v_a[p];
            req_op[p*2 +: 2]        = op_a[p];
            req_addr[p*AW +: AW]    = ad_a[p];
            req_wdata[p*DW +: DW]   = wd_a[p];
            req_cmp[p*DW +: DW]     = cm_a[p];
        end
    end

    atomic_mem_arbiter #(.NPORTS(N), .AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_cmp(req_cmp),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;
    logic [DW-1:0] model [DEPTH];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit cond, input string req, input longint act, input longint exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected response and memory update for one operation on the model.
    function automatic logic [DW:0] model_apply(input logic [1:0] op, input logic [AW-1:0] a,
                                                input logic [DW-1:0] wd, input logic [DW-1:0] cm);
        logic [DW-1:0] old;
        logic ok;
        old = model[a];
        ok = 1'b0;
        case (op)
            2'b01: model[a] = wd;
            2'b10: model[a] = wd;
            2'b11: if (old == cm) begin model[a] = wd; ok = 1'b1; end
            default: ;
        endcase
        return {ok, old};
    endfunction

    task automatic run_op(input int p, input logic [1:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input logic [DW-1:0] cm,
                          output logic [DW-1:0] old, output logic ok,
                          output int acc_cyc, output int lat);
        bit acc;
        @(negedge clk);
        v_a[p] = 1'b1; op_a[p] = op; ad_a[p] = a; wd_a[p] = wd; cm_a[p] = cm;
        acc = 0;
        acc_cyc = 0;
        while (!acc) begin
            #1;
            if (req_ready[p]) begin
                acc = 1;
                acc_cyc = cyc;
                @(posedge clk);
            end else begin
                @(negedge clk);
            end
        end
        @(negedge clk);
        v_a[p] = 1'b0;
        lat = 1;
        while (!rsp_valid[p] && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        old = rsp_data[p*DW +: DW];
        ok = rsp_ok[p];
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        logic [DW-1:0] o0, o1, o2;
        logic k0, k1, k2;
        int c0, c1, c2, l0, l1, l2;
        int winners;
        int seed;
        for (int p = 0; p < N; p++) begin
            v_a[p] = 0; op_a[p] = 0; ad_a[p] = 0; wd_a[p] = 0; cm_a[p] = 0;
        end
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(rsp_valid == '0, "R1 rsp_valid idle", rsp_valid, 0);
        check(req_ready == '0, "R1 req_ready without valid", req_ready, 0);
        for (int i = 0; i < DEPTH; i++) begin
            run_op(0, 2'b00, AW'(i), '0, '0, o0, k0, c0, l0);
            check(o0 == '0, "R1 word zero after reset", o0, 0);
        end

        // Make port 1 the last winner, then release all three ports together.
        run_op(1, 2'b00, 4'd0, '0, '0, o0, k0, c0, l0);
        fork
            run_op(0, 2'b10, 4'd1, 32'hA0A0_0001, '0, o0, k0, c0, l0);
            run_op(1, 2'b10, 4'd2, 32'hB0B0_0002, '0, o1, k1, c1, l1);
            run_op(2, 2'b10, 4'd3, 32'hC0C0_0003, '0, o2, k2, c2, l2);
        join
        void'(model_apply(2'b10, 4'd1, 32'hA0A0_0001, '0));
        void'(model_apply(2'b10, 4'd2, 32'hB0B0_0002, '0));
        void'(model_apply(2'b10, 4'd3, 32'hC0C0_0003, '0));
        // R8: order 2, 0, 1 after port 1 won last
        check(c2 < c0 && c0 < c1, "R8 round-robin order", c0 - c2, 1);
        // R7 / R10: waiting ports accepted 3 edges after each atomic acceptance
        check(c0 - c2 == 3, "R7 gap after swap", c0 - c2, 3);
        check(c1 - c0 == 3, "R10 held request served after swap", c1 - c0, 3);
        check(l0 == 3 && l1 == 3 && l2 == 3, "R7 atomic latency", l0, 3);
        check(o0 == 0 && o1 == 0 && o2 == 0, "R4 swap old value", o0 | o1 | o2, 0);

        // R2 / R3 directed
        run_op(2, 2'b01, 4'd7, 32'h1234_5678, '0, o0, k0, c0, l0);
        void'(model_apply(2'b01, 4'd7, 32'h1234_5678, '0));
        check(o0 == 0, "R3 write returns previous", o0, 0);
        check(l0 == 2, "R7 plain latency", l0, 2);
        run_op(0, 2'b00, 4'd7, '0, '0, o0, k0, c0, l0);
        check(o0 == 32'h1234_5678, "R2 read back", o0, 32'h1234_5678);
        check(k0 == 0, "R2 ok low on read", k0, 0);

        // R5 / R6 directed
        run_op(1, 2'b11, 4'd7, 32'hDEAD_BEEF, 32'h1234_5678, o0, k0, c0, l0);
        void'(model_apply(2'b11, 4'd7, 32'hDEAD_BEEF, 32'h1234_5678));
        check(k0 == 1 && o0 == 32'h1234_5678, "R5 cas hit", {k0, o0}, {1'b1, 32'h1234_5678});
        run_op(2, 2'b11, 4'd7, 32'h0BAD_0BAD, 32'h1111_1111, o0, k0, c0, l0);
        check(k0 == 0 && o0 == 32'hDEAD_BEEF, "R6 cas miss", {k0, o0}, {1'b0, 32'hDEAD_BEEF});
        run_op(0, 2'b00, 4'd7, '0, '0, o0, k0, c0, l0);
        check(o0 == 32'hDEAD_BEEF, "R6 cas miss leaves word", o0, 32'hDEAD_BEEF);

        // R9: lock race on word 9
        fork
            run_op(0, 2'b10, 4'd9, 32'd1, '0, o0, k0, c0, l0);
            run_op(1, 2'b10, 4'd9, 32'd1, '0, o1, k1, c1, l1);
            run_op(2, 2'b10, 4'd9, 32'd1, '0, o2, k2, c2, l2);
        join
        winners = int'(o0 == 0) + int'(o1 == 0) + int'(o2 == 0);
        check(winners == 1, "R9 single lock owner", winners, 1);
        check(o0 + o1 + o2 == 2, "R9 losers see 1", o0 + o1 + o2, 2);
        run_op(o0 == 0 ? 0 : (o1 == 0 ? 1 : 2), 2'b01, 4'd9, 32'd0, '0, o0, k0, c0, l0);
        run_op(1, 2'b10, 4'd9, 32'd1, '0, o0, k0, c0, l0);
        check(o0 == 0, "R9 lock free after release", o0, 0);
        model[9] = 32'd1;

        // Random single-port operations against the model (R2..R6)
        seed = $urandom(32'd2024);
        for (int n = 0; n < 400; n++) begin
            int p;
            logic [1:0] op;
            logic [AW-1:0] a;
            logic [DW-1:0] wd, cm;
            logic [DW:0] exp;
            p  = int'($urandom_range(N - 1));
            op = 2'($urandom_range(3));
            a  = AW'($urandom_range(DEPTH - 1));
            wd = $urandom();
            cm = ($urandom_range(1) == 1) ? model[a] : $urandom();
            exp = model_apply(op, a, wd, cm);
            run_op(p, op, a, wd, cm, o0, k0, c0, l0);
            if (op == 2'b11) check({k0, o0} == exp, "R5/R6 random cas", {k0, o0}, exp);
            else if (op == 2'b00) check(o0 == exp[DW-1:0] && !k0, "R2 random read", o0, exp[DW-1:0]);
            else if (op == 2'b01) check(o0 == exp[DW-1:0], "R3 random write", o0, exp[DW-1:0]);
            else check(o0 == exp[DW-1:0], "R4 random swap", o0, exp[DW-1:0]);
        end
        for (int i = 0; i < DEPTH; i++) begin
            run_op(2, 2'b00, AW'(i), '0, '0, o0, k0, c0, l0);
            check(o0 == model[i], "R3 final memory image", o0, model[i]);
        end
        finish_run();
    end
endmodule